// File: doc/BRIEF.md
# Byte-Load Instruction Sequencer

This block runs the 8-bit load instructions of a small accumulator-style processor. It fetches opcode bytes over a byte-wide memory port, decodes them and moves data between seven 8-bit registers and memory. The registers are A, B, C, D, E, H and L. It handles four kinds of load:

- register-to-register copies;
- immediate loads;
- loads and stores through the HL pair;
- loads and stores through one of two 16-bit index registers, with a signed displacement byte after the opcode.

Each instruction runs through its exact sequence of machine cycles. One clock is one T-state. The block exposes the current machine-cycle number and T-state number, and it pulses a completion strobe on the last T-state of every instruction.

The memory port is a plain strobe interface with no back-pressure. A read strobe lasts one clock, and the memory must present the byte on the following clock. A write strobe lasts one clock, and the memory must accept the byte in that clock. Neither side can stall the other.

An opcode outside the load group raises an illegal strobe and is skipped. Opcode 0x76 halts the block until reset. No flags exist or change.

Top module: `ldseq_top`

## Requirements
- R1: Reset sets the program counter to 0x0000 and all seven registers to zero. In the first clock after reset the block drives a read strobe at address 0x0000, with machine cycle 1 and T-state 1.
- R2: The 3-bit register field selects B=000, C=001, D=010, E=011, H=100, L=101 and A=111. Code 110 names memory and never a register.
- R3: Opcode 01 ddd sss, with neither field equal to 110, copies register sss into register ddd. It takes one machine cycle of 4 T-states.
- R4: Opcode 00 ddd 110, with ddd not 110, loads the next program byte into register ddd. It takes 2 machine cycles of 4 and 3 T-states.
- R5: Opcode 01 ddd 110, with ddd not 110, loads register ddd from the byte at the address formed by H (high byte) and L (low byte). The address is taken before the load writes back. Timing is 4 and 3 T-states.
- R6: Opcode 01110 sss, with sss not 110, writes register sss to the byte at address H:L. Timing is 4 and 3 T-states.
- R7: Prefix 0xDD selects index register X and prefix 0xFD selects index register Y. The prefix must be followed by a load (01 ddd 110) or a store (01110 sss) opcode, then a displacement byte. The whole instruction takes 5 machine cycles of 4, 4, 3, 5 and 3 T-states. Both index registers reset to zero.
- R8: An indexed address is the index register plus the displacement sign-extended to 16 bits, modulo 65536. For example, 0x80 added to an index of zero gives 0xFF80.
- R9: Opcode 0x76 completes in 4 T-states and sets the halted output. After that the block drives no further strobes and halted stays high until reset.
- R10: Any other unprefixed opcode pulses the illegal output on T-state 4 of its fetch, and fetching resumes at the next byte. A prefix followed by anything other than the two indexed forms does the same on T-state 4 of the second fetch, and both bytes are consumed. In either case the completion strobe does not fire and no register changes.
- R11: A read strobe is only ever high on T-state 1, and it lasts one clock. A write strobe is only high on T-state 2 of machine cycle 2 or 5. The two strobes are never high together.
- R12: The completion strobe is high for exactly one clock, on the last T-state of the last machine cycle. The next clock starts a fetch at T-state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Byte address for a read or a write |
| mem_wdata | output | 8 | Byte to be written |
| mem_rdata | input | 8 | Byte read, valid the clock after mem_rd |
| mcyc | output | 3 | Current machine-cycle number, starting at 1 |
| tstate | output | 3 | Current T-state within the machine cycle, starting at 1 |
| instr_done | output | 1 | Instruction completion strobe |
| illegal | output | 1 | Unsupported-opcode strobe |
| halted | output | 1 | High once the halt opcode has run |

## Verification
Two things can coincide in one instruction: a load's writeback of H or L, and the formation of an H:L address. This happens when a load targets H or L itself while reading through H:L. It also happens when a store through H:L directly follows an immediate load of H or L. The bench sweeps the H:L load over every destination register and the H:L store over every source register, with H and L set just beforehand by immediate loads. It then dumps the whole register file through indexed stores. The arithmetic expected values show whether the old or the new H:L was used, and whether the loaded byte landed in the right register.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;
  localparam int TW = 3;
  localparam logic [2:0] RC_MEM = 3'b110;
  localparam logic [2:0] RC_H   = 3'b100;
  localparam logic [2:0] RC_L   = 3'b101;
  localparam logic [7:0] BYTE_PFX_X = 8'hDD;
  localparam logic [7:0] BYTE_PFX_Y = 8'hFD;
  localparam logic [7:0] BYTE_HALT  = 8'h76;

  typedef enum logic [2:0] {
    MK_FETCH, MK_FETCH2, MK_IMM, MK_DISP, MK_CALC, MK_MRD, MK_MWR, MK_HALT
  } mkind_e;

  typedef enum logic [2:0] {
    OK_COPY, OK_IMM, OK_LDM, OK_STM, OK_HALT, OK_PFX, OK_BAD
  } opkind_e;

  typedef enum logic [1:0] { PX_NONE, PX_X, PX_Y } pfx_e;

  function automatic logic [TW-1:0] tlen(mkind_e k);
    case (k)
      MK_FETCH, MK_FETCH2:             return TW'(4);
      MK_IMM, MK_DISP, MK_MRD, MK_MWR: return TW'(3);
      MK_CALC:                         return TW'(5);
      default:                         return TW'(1);
    endcase
  endfunction
endpackage

// File: rtl/ldseq_decode.sv
module ldseq_decode
  import ldseq_pkg::*;
(
  input  logic [7:0] op,
  input  logic       pfx_on,
  output opkind_e    kind,
  output logic [2:0] dst,
  output logic [2:0] src
);
  assign dst = op[5:3];
  assign src = op[2:0];

  always_comb begin
    kind = OK_BAD;
    if (pfx_on) begin
      if (op[7:6] == 2'b01 && op != BYTE_HALT) begin
        if (dst == RC_MEM)      kind = OK_STM;
        else if (src == RC_MEM) kind = OK_LDM;
      end
    end else if (op == BYTE_HALT) begin
      kind = OK_HALT;
    end else if (op == BYTE_PFX_X || op == BYTE_PFX_Y) begin
      kind = OK_PFX;
    end else if (op[7:6] == 2'b01) begin
      if (dst == RC_MEM)      kind = OK_STM;
      else if (src == RC_MEM) kind = OK_LDM;
      else                    kind = OK_COPY;
    end else if (op[7:6] == 2'b00 && src == RC_MEM && dst != RC_MEM) begin
      kind = OK_IMM;
    end
  end
endmodule

// File: rtl/ldseq_regfile.sv
module ldseq_regfile
  import ldseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int RN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [$clog2(RN)-1:0]  waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [$clog2(RN)-1:0]  raddr,
  output logic [DW-1:0]          rdata,
  output logic [DW-1:0]          h_val,
  output logic [DW-1:0]          l_val
);
  localparam int RAW = $clog2(RN);

  logic [DW-1:0] r_q [RN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RN; i++) r_q[i] <= '0;
    end else begin
      for (int i = 0; i < RN; i++) begin
        if (we && waddr == RAW'(i) && RAW'(i) != RAW'(RC_MEM)) r_q[i] <= wdata;
      end
    end
  end

  assign rdata = r_q[raddr];
  assign h_val = r_q[RAW'(RC_H)];
  assign l_val = r_q[RAW'(RC_L)];
endmodule

// File: rtl/ldseq_agen.sv
module ldseq_agen #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] ofs,
  output logic [AW-1:0] sum
);
  localparam int XW = AW - DW;
  logic [AW-1:0] ofs_sx;

  generate
    if (XW > 0) begin : g_ext
      assign ofs_sx = {{XW{ofs[DW-1]}}, ofs};
    end else begin : g_noext
      assign ofs_sx = ofs[AW-1:0];
    end
  endgenerate

  assign sum = base + ofs_sx;
endmodule

// File: rtl/ldseq_top.sv
module ldseq_top
  import ldseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [TW-1:0] mcyc,
  output logic [TW-1:0] tstate,
  output logic          instr_done,
  output logic          illegal,
  output logic          halted
);
  localparam int RN  = 8;
  localparam int RAW = $clog2(RN);

  mkind_e        mk_q, mk_n;
  logic [TW-1:0] t_q, t_n, m_q, m_n;
  logic [AW-1:0] pc_q, addr_q, ix_q, iy_q, idx_base, idx_sum;
  logic [7:0]    ir_q;
  logic [DW-1:0] disp_q;
  pfx_e          pfx_q;

  opkind_e       kind;
  logic [2:0]    dst, src;
  logic [DW-1:0] src_val, h_val, l_val, rf_wd;
  logic          rf_we, t_last, fin, bad, pc_rd;

  ldseq_decode u_dec (
    .op(ir_q), .pfx_on(pfx_q != PX_NONE), .kind(kind), .dst(dst), .src(src)
  );

  ldseq_regfile #(.DW(DW), .RN(RN)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(RAW'(dst)), .wdata(rf_wd),
    .raddr(RAW'(src)), .rdata(src_val), .h_val(h_val), .l_val(l_val)
  );

  assign idx_base = (pfx_q == PX_Y) ? iy_q : ix_q;

  ldseq_agen #(.AW(AW), .DW(DW)) u_agen (
    .base(idx_base), .ofs(disp_q), .sum(idx_sum)
  );

  assign t_last = (t_q == tlen(mk_q));
  assign pc_rd  = (mk_q == MK_FETCH) || (mk_q == MK_FETCH2) ||
                  (mk_q == MK_IMM)   || (mk_q == MK_DISP);

  // Sequencing: which machine cycle follows, and where an instruction ends
  always_comb begin
    mk_n = mk_q;
    m_n  = m_q;
    t_n  = t_q + TW'(1);
    fin  = 1'b0;
    bad  = 1'b0;
    if (mk_q == MK_HALT) begin
      t_n = t_q;
    end else if (t_last) begin
      t_n = TW'(1);
      m_n = m_q + TW'(1);
      case (mk_q)
        MK_FETCH: begin
          case (kind)
            OK_COPY: fin = 1'b1;
            OK_HALT: begin mk_n = MK_HALT; m_n = m_q; fin = 1'b1; end
            OK_IMM:  mk_n = MK_IMM;
            OK_LDM:  mk_n = MK_MRD;
            OK_STM:  mk_n = MK_MWR;
            OK_PFX:  mk_n = MK_FETCH2;
            default: bad = 1'b1;
          endcase
        end
        MK_FETCH2: begin
          if (kind == OK_LDM || kind == OK_STM) mk_n = MK_DISP;
          else bad = 1'b1;
        end
        MK_DISP: mk_n = MK_CALC;
        MK_CALC: mk_n = (kind == OK_LDM) ? MK_MRD : MK_MWR;
        default: fin = 1'b1;
      endcase
      if (bad || (fin && mk_n != MK_HALT)) begin
        mk_n = MK_FETCH;
        m_n  = TW'(1);
      end
    end
  end

  // Register writeback: memory data on T2 of a read cycle, copies at fetch end
  assign rf_we = ((t_q == TW'(2)) && (mk_q == MK_IMM || mk_q == MK_MRD)) ||
                 (t_last && mk_q == MK_FETCH && kind == OK_COPY);
  assign rf_wd = (mk_q == MK_FETCH) ? src_val : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_q   <= MK_FETCH;
      t_q    <= TW'(1);
      m_q    <= TW'(1);
      pc_q   <= '0;
      ir_q   <= '0;
      disp_q <= '0;
      addr_q <= '0;
      pfx_q  <= PX_NONE;
      ix_q   <= '0;
      iy_q   <= '0;
    end else begin
      mk_q <= mk_n;
      t_q  <= t_n;
      m_q  <= m_n;
      if (pc_rd && t_q == TW'(1)) pc_q <= pc_q + AW'(1);
      if (t_q == TW'(2)) begin
        if (mk_q == MK_FETCH || mk_q == MK_FETCH2) ir_q <= mem_rdata[7:0];
        if (mk_q == MK_DISP) disp_q <= mem_rdata;
      end
      if (t_last && mk_q == MK_FETCH && kind == OK_PFX)
        pfx_q <= (ir_q == BYTE_PFX_Y) ? PX_Y : PX_X;
      else if (t_last && mk_n == MK_FETCH)
        pfx_q <= PX_NONE;
      if (t_last && mk_q == MK_FETCH) addr_q <= AW'({h_val, l_val});
      if (t_last && mk_q == MK_CALC)  addr_q <= idx_sum;
    end
  end

  assign mem_rd     = (t_q == TW'(1)) && (pc_rd || mk_q == MK_MRD);
  assign mem_wr     = (t_q == TW'(2)) && (mk_q == MK_MWR);
  assign mem_addr   = pc_rd ? pc_q : addr_q;
  assign mem_wdata  = src_val;
  assign mcyc       = m_q;
  assign tstate     = t_q;
  assign instr_done = fin;
  assign illegal    = bad;
  assign halted     = (mk_q == MK_HALT);
endmodule

// File: rtl/ldseq_checker.sv
module ldseq_checker #(
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [TW-1:0] mcyc,
  input logic [TW-1:0] tstate,
  input logic          instr_done,
  input logic          illegal,
  input logic          halted
);
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r11_rd_on_t1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> tstate == TW'(1));
  a_r11_rd_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  a_r11_wr_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (tstate == TW'(2) && (mcyc == TW'(2) || mcyc == TW'(5))));
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r9_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr && !instr_done && !illegal));
  a_r12_done_last_t: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> (tstate == TW'(3) || tstate == TW'(4)));
  a_r12_done_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (halted || (tstate == TW'(1) && mcyc == TW'(1))));
  a_r10_done_not_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_done && illegal));
  a_r7_calc_to_m5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcyc == TW'(4) && tstate == TW'(5)) |=> (mcyc == TW'(5) && tstate == TW'(1)));
endmodule

bind ldseq_top ldseq_checker #(.TW(ldseq_pkg::TW)) u_ldseq_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .mcyc(mcyc),
  .tstate(tstate), .instr_done(instr_done), .illegal(illegal), .halted(halted)
);

// File: tb/ldseq_top_bench.sv
module ldseq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd, mem_wr, instr_done, illegal, halted;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [2:0]  mcyc, tstate;

  always #4 clk = ~clk;

  ldseq_top u_ldseq_top (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mcyc(mcyc), .tstate(tstate), .instr_done(instr_done),
    .illegal(illegal), .halted(halted)
  );

  // program image (written by the stimulus) and design writes (by the memory model)
  logic [7:0] mem  [int];
  logic [7:0] wmem [int];

  function automatic logic [7:0] cur(int a);
    if (wmem.exists(a)) return wmem[a];
    if (mem.exists(a))  return mem[a];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) wmem.delete();
    else begin
      if (mem_rd) mem_rdata <= cur(int'(mem_addr));
      if (mem_wr) wmem[int'(mem_addr)] = mem_wdata;
    end
  end

  // expected timing patterns per instruction, as decimal digit strings of T-counts
  int exp_arr [512];
  int expn;

  // monitor: timing, strobe rules, counts
  int ei, pat, lt, ill, dn, rdh, viol, mchk, merr, obs;
  initial begin mchk = 0; merr = 0; end
  always @(negedge clk) begin
    if (!rst_n) begin
      ei = 0; pat = 0; lt = 0; ill = 0; dn = 0; rdh = 0; viol = 0;
    end else if (halted) begin
      if (mem_rd || mem_wr) rdh++;
    end else begin
      if (mem_rd && tstate != 3'd1) viol++;
      if (mem_wr && tstate != 3'd2) viol++;
      if (tstate == 3'd1 && lt != 0) pat = pat * 10 + lt;
      lt = int'(tstate);
      if (instr_done) begin
        dn++;
        obs = pat * 10 + lt;
        mchk++;
        if (ei >= expn) begin
          merr++;
          $display("FAIL R12 extra completion act=%0d exp=none", obs);
        end else if (obs != exp_arr[ei]) begin
          merr++;
          $display("FAIL %s timing act=%0d exp=%0d",
                   exp_arr[ei] == 4 ? "R3" : (exp_arr[ei] == 43 ? "R4" : "R7"),
                   obs, exp_arr[ei]);
        end
        ei++; pat = 0; lt = 0;
      end
      if (illegal) begin ill++; pat = 0; lt = 0; end
    end
  end

  int nchk = 0, nerr = 0, pcb = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk + mchk + 1, nerr + merr + 1);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] rc(int k);
    return (k == 6) ? 3'd7 : 3'(k);
  endfunction
  function automatic logic [7:0] v0(int k);
    return 8'(8'h11 * (k + 1));
  endfunction
  function automatic int sx(logic [7:0] d);
    return int'({{8{d[7]}}, d});
  endfunction

  task automatic newprog();
    mem.delete(); pcb = 0; expn = 0;
  endtask
  task automatic emit(logic [7:0] b);
    mem[pcb] = b; pcb++;
  endtask
  task automatic expect_t(int p);
    exp_arr[expn] = p; expn++;
  endtask
  task automatic op_imm(logic [2:0] r, logic [7:0] v);
    emit({2'b00, r, 3'b110}); emit(v); expect_t(43);
  endtask
  task automatic op_copy(logic [2:0] d, logic [2:0] s);
    emit({2'b01, d, s}); expect_t(4);
  endtask
  task automatic op_ldhl(logic [2:0] d);
    emit({2'b01, d, 3'b110}); expect_t(43);
  endtask
  task automatic op_sthl(logic [2:0] s);
    emit({5'b01110, s}); expect_t(43);
  endtask
  task automatic op_ldx(logic [7:0] p, logic [2:0] d, logic [7:0] ds);
    emit(p); emit({2'b01, d, 3'b110}); emit(ds); expect_t(44353);
  endtask
  task automatic op_stx(logic [7:0] p, logic [2:0] s, logic [7:0] ds);
    emit(p); emit({5'b01110, s}); emit(ds); expect_t(44353);
  endtask
  task automatic op_halt();
    emit(8'h76); expect_t(4);
  endtask
  task automatic preload_all();
    for (int k = 0; k < 7; k++) op_imm(rc(k), v0(k));
  endtask
  task automatic dump_all();
    for (int k = 0; k < 7; k++) op_stx(8'hDD, rc(k), 8'(8'h70 + k));
  endtask

  task automatic run_prog();
    int n;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_rd && mem_addr == 16'h0000 && tstate == 3'd1 && mcyc == 3'd1 &&
        !halted && !instr_done && !illegal, "R1 first fetch", int'(mem_addr), 0);
    n = 0;
    while (!halted && n < 4000) begin @(negedge clk); n++; end
    chk(halted, "R9 program reached halt", int'(halted), 1);
    chk(ei == expn, "R12 completions", ei, expn);
    chk(viol == 0, "R11 strobe slots", viol, 0);
  endtask

  initial begin
    logic [7:0] dl [6];
    logic [7:0] px;
    int ad, ex;
    dl = '{8'h7F, 8'h80, 8'h81, 8'hFF, 8'hC0, 8'h60};

    // R1: registers read back as zero after reset
    newprog(); dump_all(); op_halt(); run_prog();
    for (int k = 0; k < 7; k++) chk(cur(8'h70 + k) == 8'h00, "R1 reset reg", cur(8'h70 + k), 0);

    // R2 / R3: every destination and source pair of the copy
    for (int d = 0; d < 7; d++) begin
      for (int s = 0; s < 7; s++) begin
        newprog(); preload_all(); op_copy(rc(d), rc(s)); dump_all(); op_halt(); run_prog();
        for (int k = 0; k < 7; k++) begin
          ex = (k == d) ? v0(s) : v0(k);
          chk(cur(8'h70 + k) == 8'(ex), "R3 copy (R2 codes)", cur(8'h70 + k), ex);
        end
      end
    end

    // R4 / R5: load through H:L into each register, H and L set just before
    for (int d = 0; d < 7; d++) begin
      newprog(); preload_all();
      op_imm(3'd4, 8'h23); op_imm(3'd5, 8'(8'h40 + d));
      mem[32'h2340 + d] = 8'(8'hA0 + d);
      op_ldhl(rc(d)); dump_all(); op_halt(); run_prog();
      for (int k = 0; k < 7; k++) begin
        ex = (k == 4) ? 8'h23 : ((k == 5) ? 8'h40 + d : v0(k));
        if (k == d) ex = 8'hA0 + d;
        chk(cur(8'h70 + k) == 8'(ex), "R5 load via HL (R4 imm)", cur(8'h70 + k), ex);
      end
    end

    // R6: store through H:L from each register
    for (int s = 0; s < 7; s++) begin
      newprog(); preload_all();
      op_imm(3'd4, 8'h31); op_imm(3'd5, 8'(8'h20 + s));
      op_sthl(rc(s)); op_halt(); run_prog();
      ex = (s == 4) ? 8'h31 : ((s == 5) ? 8'h20 + s : v0(s));
      chk(cur(32'h3120 + s) == 8'(ex), "R6 store via HL", cur(32'h3120 + s), ex);
    end

    // R7 / R8: indexed loads and stores over both prefixes and signed displacements
    for (int p = 0; p < 2; p++) begin
      px = (p == 0) ? 8'hDD : 8'hFD;
      for (int i = 0; i < 6; i++) begin
        ad = sx(dl[i]) & 32'hFFFF;
        newprog();
        mem[ad] = dl[i] ^ 8'h5A ^ 8'(p * 8'h33);
        op_ldx(px, rc(i % 7), dl[i]);
        op_stx(8'hDD, rc(i % 7), 8'h70); op_halt(); run_prog();
        ex = dl[i] ^ 8'h5A ^ 8'(p * 8'h33);
        chk(cur(8'h70) == 8'(ex), "R8 indexed load address (R7)", cur(8'h70), ex);

        newprog(); op_imm(3'd0, 8'(8'hC3 ^ i ^ p));
        op_stx(px, 3'd0, dl[i]); op_halt(); run_prog();
        ex = 8'hC3 ^ i ^ p;
        chk(cur(ad) == 8'(ex), "R8 indexed store address (R7)", cur(ad), ex);
      end
    end

    // R10: unsupported opcodes and bad prefixed forms are skipped
    newprog();
    emit(8'h00); emit(8'h36); emit(8'hDD); emit(8'h00);
    emit(8'hFD); emit(8'h76); emit(8'hDD); emit(8'hDD);
    op_imm(3'd0, 8'h5A); op_stx(8'hDD, 3'd0, 8'h70); op_stx(8'hDD, 3'd1, 8'h71); op_halt();
    run_prog();
    chk(ill == 5, "R10 illegal strobes", ill, 5);
    chk(dn == 4, "R10 completions", dn, 4);
    chk(cur(8'h70) == 8'h5A, "R10 following load", cur(8'h70), 8'h5A);
    chk(cur(8'h71) == 8'h00, "R10 register untouched", cur(8'h71), 0);

    // R9: quiet and sticky once halted
    repeat (30) @(negedge clk);
    chk(halted, "R9 halted held", int'(halted), 1);
    chk(rdh == 0, "R9 no strobes while halted", rdh, 0);

    $display("CHECKS %0d ERRORS %0d", nchk + mchk, nerr + merr);
    $finish;
  end
endmodule